// File: doc/BRIEF.md
# Wake Event Status and Enable Registers

This block keeps a sticky record of wake-up events and drives an active-low power-management event request. A number of asynchronous event inputs are each brought into the clock domain through a two-flop synchronizer. Each input is then edge-detected, so a new rising edge on any input sets one shared status bit. A separate enable bit decides whether a set status bit is passed on to the active-low event output. Software clears the status bit by writing 1 to it.

The block sits inside a runtime register window. The host side decodes the window base and presents a small offset together with byte-wide write and read strobes and data. The status and enable bits are kept on the standby rail. Only the standby-rail power-on reset (`rst_ni`) clears them, so a pending wake request survives main-rail power-on resets and hard and soft resets. Those main-rail resets clear only the event synchronizers and edge detectors.

Top module: `wake_evt_regs`

## Requirements
- R1: Read map. Offset 0 returns the status bit in data bit 0. Offset 2 returns the enable bit in data bit 0. Data bits 7..1 always read 0. Every other offset, including 1 and 3, reads 0x00.
- R2: A write to offset 2 loads write-data bit 0 into the enable bit. Writes to offsets other than 0 and 2 change nothing.
- R3: A rising edge on any event input sets the status bit, whatever the enable bit holds. If the input is first sampled high at clock edge A, status reads 1 after edge A+2 and still reads 0 after edge A+1.
- R4: An event input held high sets the status bit only once. After software clears the bit, it stays 0 while the input remains high.
- R5: A write to offset 0 with write-data bit 0 equal to 1 clears the status bit. A write there with bit 0 equal to 0 leaves it unchanged.
- R6: If an event edge and a clearing write land on the same clock edge, the status bit ends at 1.
- R7: `evt_req_no` is low exactly when status and enable were both 1 at the previous clock edge. It is therefore registered one cycle behind those bits.
- R8: While `rst_ni` is low, status and enable are 0 and `evt_req_no` is 1.
- R9: Pulsing `main_por_ni`, `hard_rst_ni` or `soft_rst_ni` low leaves the status bit, the enable bit and `evt_req_no` unchanged.
- R10: A main-rail reset re-arms the edge detectors. An event input that is held high across the reset sets the status bit again after the reset is released.
- R11: `rd_data_o` is 0x00 while `rd_i` is low. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Standby-rail power-on reset, active low, asynchronous |
| main_por_ni | input | 1 | Main-rail power-on reset, active low |
| hard_rst_ni | input | 1 | Hard reset, active low |
| soft_rst_ni | input | 1 | Soft reset, active low |
| evt_i | input | NUM_EVT | Asynchronous wake event inputs |
| addr_i | input | ADDR_W | Register offset within the window |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, combinational |
| evt_req_no | output | 1 | Power-management event request, active low |

## Verification
The hardest case to reach from the ports is an event edge and a clearing write landing on the same clock edge, because the edge is hidden behind the synchronizer latency. The bench raises an input at a known falling edge and counts two rising edges. It then places the clearing write so that it is sampled on the edge where the synchronized rise appears. Status is already 1 at that point, so a design in which the clear wins shows up as 0. A second case holds an input high across a main-rail reset. This shows that the registers keep their value while the edge detector is re-armed.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ENABLE = 2;
  localparam int unsigned FLAG_BIT   = 0;
endpackage

// File: rtl/wake_evt_sync.sv
module wake_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], evt_i};
      prev_q <= pipe_q[LAST];
    end
  end

  assign rise_o = pipe_q[LAST] & ~prev_q;

  // R4
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wake_evt_core.sv
module wake_evt_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic status_o,
  output logic enable_o,
  output logic req_no
);
  logic status_q, enable_q, req_nq;

  // standby-rail state: only rst_ni clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      enable_q <= 1'b0;
      req_nq   <= 1'b1;
    end else begin
      status_q <= set_i | (status_q & ~clr_i);  // set wins over clear
      if (en_we_i) enable_q <= en_d_i;
      req_nq   <= ~(status_q & enable_q);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign req_no   = req_nq;

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_q);
  // R5
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !status_q);
  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(enable_q));
  // R7
  req_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (req_nq == !($past(status_q) && $past(enable_q))));
endmodule

// File: rtl/wake_evt_regs.sv
module wake_evt_regs #(
  parameter int unsigned NUM_EVT     = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              main_por_ni,
  input  logic              hard_rst_ni,
  input  logic              soft_rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              evt_req_no
);
  import wake_evt_pkg::*;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(OFS_ENABLE);

  logic [NUM_EVT-1:0] rise;
  logic sync_rst_n, set_any, clr, en_we, status, enable;
  logic unused_wdata;

  // main-rail resets only re-arm the synchronizers
  assign sync_rst_n = rst_ni & main_por_ni & hard_rst_ni & soft_rst_ni;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    wake_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (sync_rst_n),
      .evt_i  (evt_i[i]),
      .rise_o (rise[i])
    );
  end

  assign set_any = |rise;
  assign clr     = wr_i && (addr_i == STATUS_ADDR) && wr_data_i[FLAG_BIT];
  assign en_we   = wr_i && (addr_i == ENABLE_ADDR);
  assign unused_wdata = ^wr_data_i[DATA_W-1:1];

  wake_evt_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_any),
    .clr_i    (clr),
    .en_we_i  (en_we),
    .en_d_i   (wr_data_i[FLAG_BIT]),
    .status_o (status),
    .enable_o (enable),
    .req_no   (evt_req_no)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_i) begin
      if (addr_i == STATUS_ADDR)      rd_data_o[FLAG_BIT] = status;
      else if (addr_i == ENABLE_ADDR) rd_data_o[FLAG_BIT] = enable;
    end
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:1] == '0);
  // R11
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rd_data_o == '0));
  // R9
  main_rst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_rst_n && !wr_i) |=> $stable(enable));
endmodule

// File: tb/wake_evt_regs_bench.sv
module wake_evt_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EVT = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic clk = 0, rst_n = 0, main_por_n = 1, hard_n = 1, soft_n = 1;
  logic [NUM_EVT-1:0] evt = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic req_n;
  int errors = 0, checks = 0;
  bit exp_st = 0, exp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_evt_regs #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wake_evt_regs (
    .clk_i(clk), .rst_ni(rst_n), .main_por_ni(main_por_n), .hard_rst_ni(hard_n),
    .soft_rst_ni(soft_n), .evt_i(evt), .addr_i(addr), .wr_i(wr), .wr_data_i(wdata),
    .rd_i(rd), .rd_data_o(rdata), .evt_req_no(req_n));

  function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a, input bit st, input bit en);
    if (a == 0) return DATA_W'(st);
    if (a == 2) return DATA_W'(en);
    return '0;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a; rd = 1; #1; d = rdata; rd = 0; #1;
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [DATA_W-1:0] d;
    rd_reg(0, d); chk(req, d, exp_rd(0, exp_st, exp_en));
    rd_reg(2, d); chk(req, d, exp_rd(2, exp_st, exp_en));
    chk(req, req_n, !(exp_st && exp_en));
  endtask

  task automatic pulse_evt(input int i);
    @(negedge clk); evt[i] = 1;
    @(negedge clk); evt[i] = 0;
    exp_st = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    void'($urandom(32'h5eed_1234));
    idle(2);
    // R8: during standby reset
    chk("R8", req_n, 1);
    rd_reg(0, d); chk("R8", d, 0);
    rd_reg(2, d); chk("R8", d, 0);
    @(negedge clk); rst_n = 1; idle(2);
    check_state("R8");
    // R11: idle read data
    addr = 0; rd = 0; #1; chk("R11", rdata, 0);

    // R3 timing and enable independence (enable 0)
    @(negedge clk); evt[1] = 1;       // sampled at edge A
    @(posedge clk); @(negedge clk); evt[1] = 0;
    @(posedge clk); @(negedge clk);   // after A+1
    rd_reg(0, d); chk("R3", d, 0);
    @(posedge clk); @(negedge clk);   // after A+2
    rd_reg(0, d); chk("R3", d, 1);
    exp_st = 1; idle(3);
    check_state("R3");               // out stays high, enable 0

    // R7 output lag
    wr_reg(2, 8'h01); exp_en = 1;    // enable set on edge E
    chk("R7", req_n, 1);             // after E, not yet
    @(negedge clk); chk("R7", req_n, 0);
    wr_reg(0, 8'hFE);                // R5: bit0=0 no effect
    idle(1); check_state("R5");
    wr_reg(0, 8'h01); exp_st = 0;
    chk("R7", req_n, 0);
    @(negedge clk); chk("R7", req_n, 1);
    check_state("R5");

    // R6 set and clear on the same edge, status already 1
    pulse_evt(0); idle(4); check_state("R6");
    @(negedge clk); evt[2] = 1;       // edge A
    @(posedge clk); @(negedge clk); evt[2] = 0;
    @(posedge clk); @(negedge clk);   // after A+1
    addr = 0; wdata = 8'h01; wr = 1;  // sampled at A+2
    @(negedge clk); wr = 0;
    rd_reg(0, d); chk("R6", d, 1);
    idle(4); check_state("R6");

    // R4 held level sets once
    wr_reg(0, 8'h01); exp_st = 0;
    @(negedge clk); evt[3] = 1; idle(5);
    exp_st = 1; check_state("R4");
    wr_reg(0, 8'h01); exp_st = 0; idle(6);
    check_state("R4");

    // R10 held level re-armed by main reset; R9 registers kept
    @(negedge clk); hard_n = 0; idle(2); hard_n = 1; idle(5);
    exp_st = 1; check_state("R10");
    @(negedge clk); evt[3] = 0; idle(3);
    @(negedge clk); main_por_n = 0; idle(3); main_por_n = 1; idle(2);
    check_state("R9");
    @(negedge clk); soft_n = 0; idle(3); soft_n = 1; idle(2);
    check_state("R9");
    @(negedge clk); hard_n = 0; idle(3); hard_n = 1; idle(2);
    check_state("R9");

    // R1 / R2 reserved offsets
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      rd_reg(ADDR_W'(a), d); chk("R1", d, exp_rd(ADDR_W'(a), exp_st, exp_en));
    end
    wr_reg(1, 8'hFF); wr_reg(3, 8'h00); wr_reg(9, 8'h01);
    idle(2); check_state("R2");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      logic [DATA_W-1:0] rv = DATA_W'($urandom);
      logic [ADDR_W-1:0] ra = ADDR_W'($urandom);
      case (op)
        0: pulse_evt($urandom_range(0, NUM_EVT-1));
        1: begin wr_reg(0, rv); if (rv[0]) exp_st = 0; end
        2: begin wr_reg(2, rv); exp_en = rv[0]; end
        3: if (ra != 0 && ra != 2) wr_reg(ra, rv);
        default: begin rd_reg(ra, d); chk("R1", d, exp_rd(ra, exp_st, exp_en)); end
      endcase
      idle(5);
      check_state(op == 0 ? "R3" : op == 2 ? "R2" : "R5");
    end

    // R8 standby reset clears everything
    @(negedge clk); rst_n = 0; exp_st = 0; exp_en = 0; #1;
    check_state("R8");
    @(negedge clk); rst_n = 1; idle(2);
    check_state("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule